// File: doc/BRIEF.md
# Feedforward Plus Feedback Current Regulator

This block regulates the current in a resonant magnet so that it follows a sinusoidal reference. A new reference sample and a new measured-current sample arrive together with a one-cycle sample strobe, at a fixed sample rate far below the core clock (nominally one sample every 200 ns). Two independent proportional-derivative (PD) paths work on each sample pair. The forward path shapes the reference itself. The feedback path acts on the tracking error, which is the reference minus the measured current. The block adds the two path outputs, scales the sum by the fixed-point gain format and clamps it to one signed drive sample. That drive sample is held for the whole sample period, because an interpolating stage downstream reads it many times.

A small sequencer runs each sample through fixed steps. The states are `ST_OFF` (disabled, output forced to zero), `ST_IDLE` (armed, waiting for a strobe), `ST_MULT` (both PD terms being formed) and `ST_SUM` (sum, scale and clamp). The transitions are:

- `go_arm`: `ST_OFF` to `ST_IDLE` once the enable is high.
- `go_capture`: `ST_IDLE` to `ST_MULT` on a strobe.
- `go_combine`: `ST_MULT` to `ST_SUM` unconditionally.
- `go_rearm`: `ST_SUM` to `ST_IDLE` unconditionally.
- `go_kill`: any state to `ST_OFF` when the enable is low.

The four gains are plain input ports. They are captured together with the samples at the strobe.

Top module: `pd_current_regulator`

## Requirements
- R1: While reset is asserted, and after it is released, `drive` is 0 and `drive_upd` is 0 until the first result is produced.
- R2: The forward term is `kp_fwd*r + kd_fwd*(r - r_prev)`, where `r` is the reference of the current accepted strobe and `r_prev` is the reference of the previously accepted strobe.
- R3: The error is `e = ref_smp - meas_smp`, formed at 17 bits without wrap. The feedback term is `kp_fb*e + kd_fb*(e - e_prev)`, with `e_prev` taken from the previously accepted strobe.
- R4: Gains are signed 16-bit values with 12 fractional bits (4096 = 1.0). The drive is the full-width sum of both terms, shifted arithmetically right by 12, which rounds toward minus infinity.
- R5: A scaled sum above 32767 gives a drive of 32767, and one below -32768 gives -32768. The value never wraps.
- R6: A strobe sampled at clock edge N produces the new `drive` after edge N+2. `drive_upd` is 1 for exactly that one cycle.
- R7: Between updates, `drive` holds its value for every cycle.
- R8: A strobe that arrives while a sample is still being processed (`ST_MULT` or `ST_SUM`) is ignored. It causes no update and does not enter the derivative history.
- R9: With `enable` low, `drive` is 0 from the next edge on, strobes are ignored, and both derivative histories are cleared. The first sample after re-enabling therefore differences against 0.
- R10: Gains are captured at the accepted strobe. Gain changes after that edge do not affect the result of that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Regulator enable; low forces zero drive and clears history |
| smp_stb | input | 1 | One-cycle strobe marking a new sample pair |
| ref_smp | input | 16 | Signed reference sample |
| meas_smp | input | 16 | Signed measured magnet current sample |
| kp_fwd | input | 16 | Forward-path proportional gain, signed Q3.12 |
| kd_fwd | input | 16 | Forward-path derivative gain, signed Q3.12 |
| kp_fb | input | 16 | Feedback-path proportional gain, signed Q3.12 |
| kd_fb | input | 16 | Feedback-path derivative gain, signed Q3.12 |
| drive | output | 16 | Saturated signed drive sample, held between updates |
| drive_upd | output | 1 | One-cycle pulse when `drive` takes a new value |

## Verification
Each accepted strobe yields exactly one result, due in the cycle after the third rising edge counted from the edge that sampled the strobe. The driver raises the strobe at a falling edge and pushes the value it expects into a queue. The monitor looks at the outputs only at falling edges. It pops one entry whenever `drive_upd` is high and flags any pulse that arrives with an empty queue, which is how a strobe that should have been ignored gets caught. The hold, disable and reset checks sample at falling edges at fixed cycle counts after their stimulus. In those checks the expected value is the last result or zero.

// File: rtl/pdreg_pkg.sv
package pdreg_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_MULT = 2'd2,
        ST_SUM  = 2'd3
    } seq_state_t;

    localparam int NUM_PATHS = 2;
    localparam int PATH_FWD  = 0;
    localparam int PATH_FB   = 1;

endpackage

// File: rtl/pd_stage.sv
module pd_stage #(
    parameter int IN_W  = 17,
    parameter int GW    = 16,
    parameter int ACC_W = 36
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    load,
    input  logic signed [IN_W-1:0]  x_in,
    input  logic signed [GW-1:0]    kp,
    input  logic signed [GW-1:0]    kd,
    output logic signed [ACC_W-1:0] term
);

    logic signed [IN_W-1:0]  prev_q;
    logic signed [ACC_W-1:0] x_ext;
    logic signed [ACC_W-1:0] p_ext;
    logic signed [ACC_W-1:0] kp_ext;
    logic signed [ACC_W-1:0] kd_ext;
    logic signed [ACC_W-1:0] delta;
    logic signed [ACC_W-1:0] term_d;

    always_comb begin
        x_ext  = ACC_W'(x_in);
        p_ext  = ACC_W'(prev_q);
        kp_ext = ACC_W'(kp);
        kd_ext = ACC_W'(kd);
        delta  = x_ext - p_ext;
        term_d = (kp_ext * x_ext) + (kd_ext * delta);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            term   <= '0;
        end else if (clr) begin
            prev_q <= '0;
            term   <= '0;
        end else if (load) begin
            prev_q <= x_in;
            term   <= term_d;
        end
    end

    // R9: history is emptied by a clear
    a_r9_hist_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (prev_q == '0 && term == '0));

    // R8: history only moves on a load
    a_r8_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> $stable(prev_q));

endmodule

// File: rtl/sample_latch.sv
module sample_latch #(
    parameter int DW = 16,
    parameter int GW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 capture,
    input  logic signed [DW-1:0] ref_in,
    input  logic signed [DW-1:0] meas_in,
    input  logic signed [GW-1:0] kp_f_in,
    input  logic signed [GW-1:0] kd_f_in,
    input  logic signed [GW-1:0] kp_b_in,
    input  logic signed [GW-1:0] kd_b_in,
    output logic signed [DW:0]   ref_q,
    output logic signed [DW:0]   err_q,
    output logic signed [GW-1:0] kp_f_q,
    output logic signed [GW-1:0] kd_f_q,
    output logic signed [GW-1:0] kp_b_q,
    output logic signed [GW-1:0] kd_b_q
);

    logic signed [DW:0] ref_w;
    logic signed [DW:0] meas_w;
    logic signed [DW:0] err_w;

    always_comb begin
        ref_w  = (DW+1)'(ref_in);
        meas_w = (DW+1)'(meas_in);
        err_w  = ref_w - meas_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_q  <= '0;
            err_q  <= '0;
            kp_f_q <= '0;
            kd_f_q <= '0;
            kp_b_q <= '0;
            kd_b_q <= '0;
        end else if (clr) begin
            ref_q  <= '0;
            err_q  <= '0;
        end else if (capture) begin
            ref_q  <= ref_w;
            err_q  <= err_w;
            kp_f_q <= kp_f_in;
            kd_f_q <= kd_f_in;
            kp_b_q <= kp_b_in;
            kd_b_q <= kd_b_in;
        end
    end

    // R10: captured gains stay put until the next capture
    a_r10_gain_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(kp_f_q) && $stable(kd_f_q) &&
                      $stable(kp_b_q) && $stable(kd_b_q)));

endmodule

// File: rtl/drive_sat.sv
module drive_sat #(
    parameter int DW    = 16,
    parameter int ACC_W = 36,
    parameter int FRAC  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    upd_in,
    input  logic signed [ACC_W-1:0] term_a,
    input  logic signed [ACC_W-1:0] term_b,
    output logic signed [DW-1:0]    drive_o,
    output logic                    upd_o
);

    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(64'sd1 <<< (DW-1)));

    logic signed [ACC_W-1:0] total;
    logic signed [ACC_W-1:0] scaled;
    logic signed [DW-1:0]    clip;

    always_comb begin
        total  = term_a + term_b;
        scaled = total >>> FRAC;
        if (scaled > MAXV)
            clip = MAXV[DW-1:0];
        else if (scaled < MINV)
            clip = MINV[DW-1:0];
        else
            clip = scaled[DW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_o <= '0;
            upd_o   <= 1'b0;
        end else if (clr) begin
            drive_o <= '0;
            upd_o   <= 1'b0;
        end else begin
            upd_o <= upd_in;
            if (upd_in)
                drive_o <= clip;
        end
    end

    // R5: clamp at the top
    a_r5_clip_high: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_in && !clr && scaled > MAXV) |=> (drive_o == MAXV[DW-1:0]));

    // R5: clamp at the bottom
    a_r5_clip_low: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_in && !clr && scaled < MINV) |=> (drive_o == MINV[DW-1:0]));

endmodule

// File: rtl/pd_current_regulator.sv
module pd_current_regulator
    import pdreg_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          smp_stb,
    input  logic [DW-1:0] ref_smp,
    input  logic [DW-1:0] meas_smp,
    input  logic [GW-1:0] kp_fwd,
    input  logic [GW-1:0] kd_fwd,
    input  logic [GW-1:0] kp_fb,
    input  logic [GW-1:0] kd_fb,
    output logic [DW-1:0] drive,
    output logic          drive_upd
);

    localparam int IN_W  = DW + 1;
    localparam int ACC_W = GW + DW + 4;

    seq_state_t state_q;
    seq_state_t state_d;

    logic clr;
    logic capture;
    logic load;
    logic combine;

    logic signed [IN_W-1:0]  ref_q;
    logic signed [IN_W-1:0]  err_q;
    logic signed [GW-1:0]    kp_f_q;
    logic signed [GW-1:0]    kd_f_q;
    logic signed [GW-1:0]    kp_b_q;
    logic signed [GW-1:0]    kd_b_q;

    logic signed [IN_W-1:0]  path_x  [NUM_PATHS];
    logic signed [GW-1:0]    path_kp [NUM_PATHS];
    logic signed [GW-1:0]    path_kd [NUM_PATHS];
    logic signed [ACC_W-1:0] path_t  [NUM_PATHS];

    logic signed [DW-1:0]    drive_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;                       // go_kill
        end else begin
            unique case (state_q)
                ST_OFF:  state_d = ST_IDLE;         // go_arm
                ST_IDLE: if (smp_stb) state_d = ST_MULT;  // go_capture
                ST_MULT: state_d = ST_SUM;          // go_combine
                ST_SUM:  state_d = ST_IDLE;         // go_rearm
                default: state_d = ST_OFF;
            endcase
        end
    end

    // sequencer outputs
    always_comb begin
        clr     = !enable;
        capture = 1'b0;
        load    = 1'b0;
        combine = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_IDLE: capture = enable && smp_stb;
            ST_MULT: load    = enable;
            ST_SUM:  combine = enable;
            default: ;
        endcase
    end

    sample_latch #(
        .DW (DW),
        .GW (GW)
    ) i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .capture (capture),
        .ref_in  ($signed(ref_smp)),
        .meas_in ($signed(meas_smp)),
        .kp_f_in ($signed(kp_fwd)),
        .kd_f_in ($signed(kd_fwd)),
        .kp_b_in ($signed(kp_fb)),
        .kd_b_in ($signed(kd_fb)),
        .ref_q   (ref_q),
        .err_q   (err_q),
        .kp_f_q  (kp_f_q),
        .kd_f_q  (kd_f_q),
        .kp_b_q  (kp_b_q),
        .kd_b_q  (kd_b_q)
    );

    always_comb begin
        path_x[PATH_FWD]  = ref_q;
        path_kp[PATH_FWD] = kp_f_q;
        path_kd[PATH_FWD] = kd_f_q;
        path_x[PATH_FB]   = err_q;
        path_kp[PATH_FB]  = kp_b_q;
        path_kd[PATH_FB]  = kd_b_q;
    end

    for (genvar gi = 0; gi < NUM_PATHS; gi++) begin : g_path
        pd_stage #(
            .IN_W  (IN_W),
            .GW    (GW),
            .ACC_W (ACC_W)
        ) i_pd (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .load  (load),
            .x_in  (path_x[gi]),
            .kp    (path_kp[gi]),
            .kd    (path_kd[gi]),
            .term  (path_t[gi])
        );
    end

    drive_sat #(
        .DW    (DW),
        .ACC_W (ACC_W),
        .FRAC  (FRAC)
    ) i_sat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .upd_in  (combine),
        .term_a  (path_t[PATH_FWD]),
        .term_b  (path_t[PATH_FB]),
        .drive_o (drive_s),
        .upd_o   (drive_upd)
    );

    assign drive = drive_s;

    // R9: disabled means zero drive, no pulse
    a_r9_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (drive == '0 && !drive_upd));

    // R7: drive holds except at an update
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q != ST_SUM) |=> $stable(drive));

    // R8: processing cannot be restarted by a strobe
    a_r8_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MULT) |=> (state_q == ST_SUM || state_q == ST_OFF));

    // R6: update pulse lasts one cycle
    a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        drive_upd |=> !drive_upd);

    // R6: an update is always preceded by a sum step
    a_r6_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_upd) |-> $past(state_q == ST_SUM));

endmodule

// File: tb/test_pd_current_regulator.sv
module test_pd_current_regulator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        smp_stb = 1'b0;
    logic [15:0] ref_smp = '0;
    logic [15:0] meas_smp = '0;
    logic [15:0] kp_fwd = '0;
    logic [15:0] kd_fwd = '0;
    logic [15:0] kp_fb = '0;
    logic [15:0] kd_fb = '0;
    logic [15:0] drive;
    logic        drive_upd;

    int n_chk = 0;
    int n_bad = 0;
    longint r_prev = 0;
    longint e_prev = 0;
    int exp_q[$];
    string tag_q[$];
    int last_drive = 0;

    always #2 clk = ~clk;

    pd_current_regulator i_pd_current_regulator (
        .clk(clk), .rst_n(rst_n), .enable(enable), .smp_stb(smp_stb),
        .ref_smp(ref_smp), .meas_smp(meas_smp),
        .kp_fwd(kp_fwd), .kd_fwd(kd_fwd), .kp_fb(kp_fb), .kd_fb(kd_fb),
        .drive(drive), .drive_upd(drive_upd)
    );

    task automatic chk(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int model(longint r, longint m);
        longint e, s;
        e = r - m;
        s = longint'($signed(kp_fwd)) * r + longint'($signed(kd_fwd)) * (r - r_prev)
          + longint'($signed(kp_fb)) * e + longint'($signed(kd_fb)) * (e - e_prev);
        s = s >>> 12;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        r_prev = r;
        e_prev = e;
        return int'(s);
    endfunction

    // driver: strobe one sample, push the expected result
    task automatic send(string req, int r, int m, bit expect_out = 1'b1);
        @(negedge clk);
        ref_smp  = 16'(r);
        meas_smp = 16'(m);
        if (expect_out) begin
            exp_q.push_back(model(longint'(r), longint'(m)));
            tag_q.push_back(req);
        end
        smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic gains(int a, int b, int c, int d);
        kp_fwd = 16'(a); kd_fwd = 16'(b); kp_fb = 16'(c); kd_fb = 16'(d);
    endtask

    // monitor: compare every update against the queue
    always @(negedge clk) begin
        if (rst_n && drive_upd) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R8/R9 unexpected update actual=%0d expected=none",
                         $signed(drive));
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, int'($signed(drive)), e);
                last_drive = e;
            end
        end
    end

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 drive in reset", int'(drive), 0);
        chk("R1 upd in reset", int'(drive_upd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 drive after reset", int'(drive), 0);
        enable = 1'b1;
        repeat (2) @(negedge clk);

        // R2 forward proportional only
        gains(4096, 0, 0, 0);
        send("R2 fwd kp", 1000, 0); settle();
        send("R2 fwd kp neg", -2500, 77); settle();
        // R2 forward derivative
        gains(0, 8192, 0, 0);
        send("R2 fwd kd", 300, 0); settle();
        gains(2048, 4096, 0, 0);
        send("R2 fwd kp+kd", -100, 0); settle();

        // R3 feedback on error
        gains(0, 0, 4096, 0);
        send("R3 fb kp", 500, 1500); settle();
        send("R3 fb wide err", 32767, -32768); settle();
        gains(0, 0, 0, 4096);
        send("R3 fb kd", 100, 40); settle();
        gains(4096, 1024, 2048, 512);
        send("R3 mixed", 1234, 1000); settle();
        send("R3 mixed b", -4321, 250); settle();

        // R4 rounding toward minus infinity
        gains(1, 0, 0, 0);
        send("R4 floor neg", -1, 0); settle();
        send("R4 floor pos", 4095, 0); settle();
        gains(3, 0, 0, 0);
        send("R4 floor frac", -5000, 0); settle();

        // R5 saturation
        gains(32767, 0, 0, 0);
        send("R5 clip high", 20000, 0); settle();
        send("R5 clip low", -20000, 0); settle();
        gains(-32768, -32768, -32768, -32768);
        send("R5 clip all paths", 32767, -32768); settle();

        // R6 latency: strobe at edge N, new value visible after edge N+2
        gains(4096, 0, 0, 0);
        @(negedge clk);
        ref_smp = 16'(777); meas_smp = '0;
        exp_q.push_back(model(777, 0)); tag_q.push_back("R6 value");
        smp_stb = 1'b1;
        @(negedge clk); smp_stb = 1'b0;
        chk("R6 no pulse after N", int'(drive_upd), 0);
        @(negedge clk);
        chk("R6 no pulse after N+1", int'(drive_upd), 0);
        @(negedge clk);
        chk("R6 pulse after N+2", int'(drive_upd), 1);
        @(negedge clk);
        chk("R6 pulse one cycle", int'(drive_upd), 0);

        // R7 hold between updates
        repeat (3) begin
            @(negedge clk);
            chk("R7 hold", int'($signed(drive)), last_drive);
        end

        // R8 strobe while busy ignored
        gains(4096, 4096, 0, 0);
        send("R8 accepted", 2000, 0);
        ref_smp = 16'(9999); smp_stb = 1'b1;
        @(negedge clk); smp_stb = 1'b0;
        settle();
        chk("R8 queue drained", exp_q.size(), 0);
        send("R8 history intact", 2100, 0); settle();

        // R10 gains captured at strobe
        gains(4096, 0, 0, 0);
        @(negedge clk);
        ref_smp = 16'(1500); meas_smp = '0;
        exp_q.push_back(model(1500, 0)); tag_q.push_back("R10 old gains");
        smp_stb = 1'b1;
        @(negedge clk); smp_stb = 1'b0;
        gains(16384, 0, 0, 0);
        settle();
        gains(4096, 0, 0, 0);

        // R9 disable: zero drive, ignored strobe, cleared history
        gains(4096, 4096, 4096, 4096);
        send("R9 before off", 3000, 1000); settle();
        enable = 1'b0;
        @(negedge clk);
        chk("R9 drive zero", int'(drive), 0);
        send("R9 ignored", 5000, 0, 1'b0); settle();
        chk("R9 still zero", int'(drive), 0);
        r_prev = 0; e_prev = 0;
        enable = 1'b1;
        repeat (2) @(negedge clk);
        send("R9 history cleared", 3000, 1000); settle();

        chk("R6 all results seen", exp_q.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule